// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port Controller

This block is one general-purpose I/O port of a small controller. Each of its pins has a direction bit and an output bit, and the pad level can be read back. Software reaches the three per-port registers at three addresses of a narrow register bus, with a write enable and a read enable. The output bit does two jobs. When the pin drives, it sets the driven level. When the pin is an input, it turns the weak pull-up on. A write of ones to the pin-level address flips the matching output bits, so a level can be toggled without a read-modify-write sequence.

Pad levels enter through a two-flop synchronizer clocked by the port clock. A chip-wide sleep request clamps the synchronizer input to zero, so that floating pads cannot toggle logic while the chip idles. A chip-wide pull-up kill input turns off every pull-up, whatever the registers hold.

Top module: `gpio_port8`

## Requirements
- R1: Address map, with `busAddr` decoded as 0 = pin level (toggle on write), 1 = direction, 2 = output. While `busRdEn` is high, `busRdData` shows the addressed register in the same cycle; otherwise it shows 0.
- R2: A write to address 1 loads the direction register at the next clock edge. `padOutEn` equals the direction register (1 = output, 0 = input).
- R3: A write to address 2 loads the output register at the next clock edge. `padOut` equals the output register.
- R4: `padPullEn[i]` is high exactly when pin i is an input, its output bit is 1 and `pullupDisable` is low.
- R5: While `pullupDisable` is high, every bit of `padPullEn` is 0 and no register changes.
- R6: A write to address 0 inverts each output bit whose data bit is 1. Data bits of 0 leave the output bit unchanged, and the direction register is not touched.
- R7: A pad level present at clock edge k reads back through address 0 after edge k+1 and not earlier.
- R8: While `sleepReq` is high, the synchronizer samples 0, so pin reads return 0 two edges after sleep begins.
- R9: The asynchronous active-low reset `rstN` clears the direction register, the output register and the synchronizer. Every pin then comes up as an input with no pull-up.
- R10: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select |
| busWrEn | input | 1 | Write enable |
| busRdEn | input | 1 | Read enable |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, 0 when not reading |
| pullupDisable | input | 1 | Chip-wide pull-up kill |
| sleepReq | input | 1 | Chip-wide sleep request, clamps pad sampling |
| padIn | input | 8 | Raw pad levels |
| padOutEn | output | 8 | Per-pin driver enable |
| padOut | output | 8 | Per-pin driven level |
| padPullEn | output | 8 | Per-pin pull-up enable |

## Verification
Several relations are checked on every cycle:
- a pull-up never coexists with an enabled driver;
- the kill input silences all pull-ups;
- direction and toggle writes land on the pads one edge later;
- the unused address always reads zero;
- a pin read equals the sleep-gated pad level from two edges earlier.

Other behaviours only show up in the bench's scenarios:
- the dual meaning of the output bit across sequences of direction changes;
- toggle masks of zero;
- the exact edge on which a new pad level first becomes visible;
- the clamp taking hold after sleep begins;
- a reset landing in the middle of activity.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic wrToggle;
    logic rdDir;
    logic rdOut;
    logic rdPin;
  } portStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic        [1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output portStrobe_t       strobe
);
  regSel_e sel;

  always_comb begin
    sel = regSel_e'(busAddr);
    strobe = '0;
    unique case (sel)
      SEL_PIN: begin
        strobe.wrToggle = busWrEn;
        strobe.rdPin    = busRdEn;
      end
      SEL_DIR: begin
        strobe.wrDir = busWrEn;
        strobe.rdDir = busRdEn;
      end
      SEL_OUT: begin
        strobe.wrOut = busWrEn;
        strobe.rdOut = busRdEn;
      end
      SEL_NONE: strobe = '0;
      default:  strobe = '0;
    endcase
  end
endmodule

// File: rtl/gpio_dpath.sv
module gpio_dpath
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [WIDTH-1:0]  wrData,
  input  logic              pullupDisable,
  input  logic              sleepReq,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  padOutEn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padPullEn
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] dirReg;
  logic [WIDTH-1:0] outReg;
  logic [WIDTH-1:0] gatedIn;
  logic [WIDTH-1:0] syncStage [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
    end else if (strobe.wrDir) begin
      dirReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
    end else if (strobe.wrOut) begin
      outReg <= wrData;
    end else if (strobe.wrToggle) begin
      outReg <= outReg ^ wrData;
    end
  end

  assign gatedIn = sleepReq ? '0 : padIn;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncStage[s] <= '0;
      end else begin
        syncStage[s] <= (s == 0) ? gatedIn : syncStage[(s == 0) ? 0 : s - 1];
      end
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign padOutEn[i]  = dirReg[i];
    assign padOut[i]    = outReg[i];
    assign padPullEn[i] = ~dirReg[i] & outReg[i] & ~pullupDisable;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdDir) rdData = dirReg;
    if (strobe.rdOut) rdData = outReg;
    if (strobe.rdPin) rdData = syncStage[LAST];
  end
endmodule

// File: rtl/gpio_port8.sv
module gpio_port8
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busAddr,
  input  logic             busWrEn,
  input  logic             busRdEn,
  input  logic [WIDTH-1:0] busWrData,
  output logic [WIDTH-1:0] busRdData,
  input  logic             pullupDisable,
  input  logic             sleepReq,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOutEn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padPullEn
);
  portStrobe_t strobe;

  gpio_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobe  (strobe)
  );

  gpio_dpath #(
    .WIDTH       (WIDTH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (busWrData),
    .pullupDisable (pullupDisable),
    .sleepReq      (sleepReq),
    .padIn         (padIn),
    .rdData        (busRdData),
    .padOutEn      (padOutEn),
    .padOut        (padOut),
    .padPullEn     (padPullEn)
  );
endmodule

// File: rtl/gpio_port8_checker.sv
module gpio_port8_checker #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWrEn,
  input logic             busRdEn,
  input logic [WIDTH-1:0] busWrData,
  input logic [WIDTH-1:0] busRdData,
  input logic             pullupDisable,
  input logic             sleepReq,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOutEn,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padPullEn
);
  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R4: a pin never pulls up while it drives
  p_no_pull_on_driver_r4: assert property (@(posedge clk) disable iff (!rstN)
    (padPullEn & padOutEn) == '0);

  // R5: the kill input silences every pull-up
  p_pull_kill_r5: assert property (@(posedge clk) disable iff (!rstN)
    pullupDisable |-> padPullEn == '0);

  // R2: a direction write reaches the driver enables one edge later
  p_dir_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) |=> padOutEn == $past(busWrData));

  // R6: a toggle write flips the masked output bits
  p_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0) |=> padOut == ($past(padOut) ^ $past(busWrData)));

  // R10: the unused address reads zero
  p_unmapped_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 2'd3) |-> busRdData == '0);

  // R9: registers sit cleared while reset is held
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |=> (padOutEn == '0 && padOut == '0));

  // R7, R8: pin reads equal the sleep-gated pad from two edges back
  if (SYNC_STAGES == 2) begin : g_sync_chk
    p_sync_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
      (busRdEn && busAddr == 2'd0 && sinceRst >= 2'd2)
        |-> busRdData == $past(sleepReq ? '0 : padIn, 2));
  end
endmodule

bind gpio_port8 gpio_port8_checker #(
  .WIDTH       (WIDTH),
  .SYNC_STAGES (SYNC_STAGES)
) u_checker (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .busWrEn       (busWrEn),
  .busRdEn       (busRdEn),
  .busWrData     (busWrData),
  .busRdData     (busRdData),
  .pullupDisable (pullupDisable),
  .sleepReq      (sleepReq),
  .padIn         (padIn),
  .padOutEn      (padOutEn),
  .padOut        (padOut),
  .padPullEn     (padPullEn)
);

// File: tb/tb_gpio_port8.sv
module tb_gpio_port8;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  // {addr[41:40], data[39:32], expOutEn[31:24], expOut[23:16], expPull[15:8], pad[7:0] unused}
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd2, 8'hA5, 8'h00, 8'hA5, 8'hA5, 8'h00},  // R3 R4
    {2'd1, 8'h0F, 8'h0F, 8'hA5, 8'hA0, 8'h00},  // R2 R4
    {2'd0, 8'h3C, 8'h0F, 8'h99, 8'h90, 8'h00},  // R6
    {2'd0, 8'h00, 8'h0F, 8'h99, 8'h90, 8'h00},  // R6 zero mask
    {2'd3, 8'hFF, 8'h0F, 8'h99, 8'h90, 8'h00},  // R10
    {2'd1, 8'hFF, 8'hFF, 8'h99, 8'h00, 8'h00},  // R2 R4
    {2'd0, 8'hFF, 8'hFF, 8'h66, 8'h00, 8'h00},  // R6
    {2'd1, 8'h00, 8'h00, 8'h66, 8'h66, 8'h00}   // R4
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       pullupDisable = 1'b0;
  logic       sleepReq = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOutEn, padOut, padPullEn;

  int applied = 0;
  int errors  = 0;
  bit done    = 1'b0;

  gpio_port8 dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .pullupDisable(pullupDisable), .sleepReq(sleepReq), .padIn(padIn),
    .padOutEn(padOutEn), .padOut(padOut), .padPullEn(padPullEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R9 reset outEn", padOutEn, 8'h00);
    check("R9 reset out", padOut, 8'h00);
    check("R9 reset pull", padPullEn, 8'h00);
    rstN = 1'b1;
    busRead(2'd0, rd); check("R9 reset pin", rd, 8'h00);
    check("R1 idle read zero", busRdData, 8'h00);

    for (int v = 0; v < NVEC; v++) begin
      busWrite(VEC[v][41:40], VEC[v][39:32]);
      check("R2 vec outEn", padOutEn, VEC[v][31:24]);
      check("R3 R6 vec out", padOut, VEC[v][23:16]);
      check("R4 vec pull", padPullEn, VEC[v][15:8]);
    end

    busRead(2'd1, rd); check("R1 dir readback", rd, 8'h00);
    busRead(2'd2, rd); check("R1 out readback", rd, 8'h66);
    busRead(2'd3, rd); check("R10 unmapped read", rd, 8'h00);

    // R5: kill input
    @(negedge clk); pullupDisable = 1'b1;
    #1 check("R5 pull kill", padPullEn, 8'h00);
    busRead(2'd2, rd); check("R5 out kept", rd, 8'h66);
    @(negedge clk); pullupDisable = 1'b0;
    #1 check("R5 pull restored", padPullEn, 8'h66);

    // R7: synchronizer latency
    @(negedge clk);
    busAddr = 2'd0; busRdEn = 1'b1; padIn = 8'h5A;
    #1 check("R7 zero edges", busRdData, 8'h00);
    @(negedge clk); check("R7 one edge", busRdData, 8'h00);
    @(negedge clk); check("R7 two edges", busRdData, 8'h5A);
    check("R6 pin write untouched by pad", padOut, 8'h66);

    // R8: sleep clamp
    sleepReq = 1'b1;
    @(negedge clk); check("R8 sleep one edge", busRdData, 8'h5A);
    @(negedge clk); check("R8 sleep two edges", busRdData, 8'h00);
    sleepReq = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R8 wake", busRdData, 8'h5A);
    busRdEn = 1'b0;

    // R9: reset mid-run
    busWrite(2'd1, 8'hC3);
    @(negedge clk); rstN = 1'b0;
    #1 check("R9 async outEn", padOutEn, 8'h00);
    check("R9 async out", padOut, 8'h00);
    @(negedge clk); rstN = 1'b1;
    busRead(2'd0, rd); check("R9 sync cleared", rd, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule